// File: doc/BRIEF.md
# Acknowledge-Gated Timer Interrupt Pacer

This block takes the expiry pulses of a periodic timer and turns them into interrupt pulses at a pace the interrupt consumer can sustain. Every expiry adds one to a backlog of undelivered ticks. An interrupt is launched only when the consumer has acknowledged the previous one, so a consumer that fell behind receives the missed ticks one after another and none are lost or merged.

A delivery opportunity strobe marks the cycles in which an interrupt may be launched. A launch clears an internal ready flag. An acknowledge pulse sets the flag again and takes one tick off the backlog. Writing a new count into the timer, signalled by a reprogram strobe, discards the backlog and rearms the flag, as reset does. The pending-work output tells the delivery logic that a launch would succeed at the next opportunity.

Top module: `ack_tick_pacer`

## Requirements
- R1: After reset the backlog is zero, the ready flag is set, `irq_o` is 0 and `pend_work_o` is 0.
- R2: Each cycle with `expire_i` high (and neither `ack_i` nor `reprog_i`) raises the backlog by one.
- R3: An interrupt is launched in a cycle with `slot_i` high, a nonzero backlog, the ready flag set and `reprog_i` low; `irq_o` is high in the cycle that follows.
- R4: A launch clears the ready flag; until it is set again further `slot_i` strobes launch nothing and `pend_work_o` reads 0.
- R5: `ack_i` lowers the backlog by one but never below zero, and sets the ready flag.
- R6: `irq_o` is a one-cycle pulse; it is never high in two consecutive cycles.
- R7: `reprog_i` clears the backlog and sets the ready flag, overriding `expire_i`, `ack_i` and `slot_i` in the same cycle, and launches nothing.
- R8: `pend_work_o` is 1 exactly when the backlog is nonzero and the ready flag is set.
- R9: The backlog saturates at 2^CNT_W-1; further expiries leave it at that value.
- R10: `ack_i` and `expire_i` in the same cycle leave the backlog unchanged, while the ready flag is still set.
- R11: When a launch and `ack_i` fall in the same cycle, the ready flag ends cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| expire_i | input | 1 | Timer expiry pulse |
| ack_i | input | 1 | Interrupt acknowledge pulse |
| reprog_i | input | 1 | Timer count was rewritten |
| slot_i | input | 1 | Delivery opportunity strobe |
| irq_o | output | 1 | One-cycle interrupt pulse |
| pend_work_o | output | 1 | A launch would succeed at the next opportunity |

## Verification
All four inputs act at the next rising edge: backlog and ready flag change at that edge, so `pend_work_o` shows the new state one cycle after the stimulus, and `irq_o` is high in the cycle directly after the `slot_i` that launched it. The bench drives inputs just after a falling edge, advances a bench-side model of backlog and flag at the rising edge, and compares both outputs at the following falling edge, so every result is sampled in the exact cycle it is due. Backlog values that have no port of their own, such as saturation and the zero floor, are read out by counting how many acknowledges it takes for `pend_work_o` to fall.

// File: rtl/ack_tick_pacer_pkg.sv
package ack_tick_pacer_pkg;

    typedef struct packed {
        logic ready;
        logic irq;
    } gate_state_t;

    localparam gate_state_t GATE_RESET = '{ready: 1'b1, irq: 1'b0};

endpackage

// File: rtl/ack_tick_backlog.sv
module ack_tick_backlog #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             dec_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             nonzero_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } backlog_t;

    backlog_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (inc_i && !dec_i) begin
            if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (dec_i && !inc_i) begin
            if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o     = st_q.cnt;
    assign nonzero_o = (st_q.cnt != '0);

endmodule

// File: rtl/ack_tick_gate.sv
module ack_tick_gate
    import ack_tick_pacer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic work_i,
    input  logic slot_i,
    input  logic ack_i,
    input  logic rearm_i,
    output logic ready_o,
    output logic launch_o,
    output logic irq_o
);
    gate_state_t st_d, st_q;
    logic        launch;

    always_comb begin
        launch = slot_i && work_i && st_q.ready && !rearm_i;
        st_d   = st_q;
        st_d.irq = launch;
        if (rearm_i) begin
            st_d.ready = 1'b1;
        end else if (launch) begin
            st_d.ready = 1'b0;
        end else if (ack_i) begin
            st_d.ready = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= GATE_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready_o  = st_q.ready;
    assign launch_o = launch;
    assign irq_o    = st_q.irq;

endmodule

// File: rtl/ack_tick_pacer.sv
module ack_tick_pacer #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic ack_i,
    input  logic reprog_i,
    input  logic slot_i,
    output logic irq_o,
    output logic pend_work_o
);
    logic [CNT_W-1:0] backlog_q;
    logic             backlog_nz;
    logic             ready_q;
    logic             launch;

    ack_tick_backlog #(.CNT_W(CNT_W)) u_backlog (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_i     (expire_i),
        .dec_i     (ack_i),
        .clr_i     (reprog_i),
        .cnt_o     (backlog_q),
        .nonzero_o (backlog_nz)
    );

    ack_tick_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .work_i   (backlog_nz),
        .slot_i   (slot_i),
        .ack_i    (ack_i),
        .rearm_i  (reprog_i),
        .ready_o  (ready_q),
        .launch_o (launch),
        .irq_o    (irq_o)
    );

    assign pend_work_o = backlog_nz && ready_q;

endmodule

// File: rtl/ack_tick_pacer_chk.sv
module ack_tick_pacer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             expire_i,
    input logic             ack_i,
    input logic             reprog_i,
    input logic             slot_i,
    input logic             irq_o,
    input logic             pend_work_o,
    input logic [CNT_W-1:0] backlog_q,
    input logic             ready_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // R3: an interrupt is always preceded by an opportunity strobe
    a_r3_irq_after_slot: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(slot_i) && !$past(reprog_i));

    // R6
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R4
    a_r4_launch_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !ready_q);

    // R7
    a_r7_reprog_clears: assert property (@(posedge clk) disable iff (!rst_n)
        reprog_i |=> (backlog_q == '0) && ready_q && !irq_o);

    // R5
    a_r5_ack_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !slot_i && !reprog_i) |=> ready_q);

    // R9
    a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (backlog_q == CNT_MAX && !ack_i && !reprog_i) |=> backlog_q == CNT_MAX);

    // R10
    a_r10_ack_and_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && expire_i && !reprog_i) |=> $stable(backlog_q));

endmodule

bind ack_tick_pacer ack_tick_pacer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .expire_i    (expire_i),
    .ack_i       (ack_i),
    .reprog_i    (reprog_i),
    .slot_i      (slot_i),
    .irq_o       (irq_o),
    .pend_work_o (pend_work_o),
    .backlog_q   (backlog_q),
    .ready_q     (ready_q)
);

// File: tb/ack_tick_pacer_test.sv
module ack_tick_pacer_test;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;
    localparam int CNT_MAX    = (1 << CNT_W) - 1;
    localparam int WDOG_LIMIT = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic expire_i = 1'b0, ack_i = 1'b0, reprog_i = 1'b0, slot_i = 1'b0;
    logic irq_o, pend_work_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int m_cnt = 0;
    bit m_ready = 1'b1;
    bit m_irq = 1'b0;
    bit prev_irq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ack_tick_pacer #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .expire_i(expire_i), .ack_i(ack_i),
        .reprog_i(reprog_i), .slot_i(slot_i), .irq_o(irq_o), .pend_work_o(pend_work_o)
    );

    function automatic int next_cnt(int c, bit e, bit a, bit r);
        if (r) return 0;
        if (e && !a) return (c == CNT_MAX) ? c : c + 1;
        if (a && !e) return (c == 0) ? 0 : c - 1;
        return c;
    endfunction

    function automatic bit launches(int c, bit rdy, bit s, bit r);
        return s && (c != 0) && rdy && !r;
    endfunction

    function automatic bit next_ready(int c, bit rdy, bit a, bit s, bit r);
        if (r) return 1'b1;
        if (launches(c, rdy, s, r)) return 1'b0;
        if (a) return 1'b1;
        return rdy;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // one cycle: drive after falling edge, model at rising edge, compare at next falling edge
    task automatic step(bit e, bit a, bit r, bit s);
        bit l;
        expire_i = e; ack_i = a; reprog_i = r; slot_i = s;
        @(posedge clk);
        l       = launches(m_cnt, m_ready, s, r);
        m_ready = next_ready(m_cnt, m_ready, a, s, r);
        m_cnt   = next_cnt(m_cnt, e, a, r);
        m_irq   = l;
        @(negedge clk);
        check(irq_o === m_irq, "R3 irq", int'(irq_o), int'(m_irq));
        check(pend_work_o === ((m_cnt != 0) && m_ready), "R8 pend",
              int'(pend_work_o), int'((m_cnt != 0) && m_ready));
        if (irq_o) check(!prev_irq, "R6 double pulse", 1, 0);
        prev_irq = irq_o;
        expire_i = 0; ack_i = 0; reprog_i = 0; slot_i = 0;
    endtask

    // acknowledge until pend_work_o falls; returns number of acks
    task automatic drain_count(output int n);
        n = 0;
        while (pend_work_o && n < CNT_MAX + 5) begin
            step(0, 1, 0, 0);
            n++;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WDOG_LIMIT) begin
                errors++; checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, WDOG_LIMIT);
                finish_run();
            end
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check(irq_o === 1'b0 && pend_work_o === 1'b0, "R1 reset outputs",
              int'({irq_o, pend_work_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: one expiry makes work visible
        step(1, 0, 0, 0);
        check(pend_work_o === 1'b1, "R2 expiry raises backlog", int'(pend_work_o), 1);
        // R3: launch one cycle after slot
        step(0, 0, 0, 1);
        check(irq_o === 1'b1, "R3 irq after slot", int'(irq_o), 1);
        check(pend_work_o === 1'b0, "R4 pend hidden after launch", int'(pend_work_o), 0);
        step(1, 0, 0, 1);
        check(irq_o === 1'b0, "R4 no launch while not ready", int'(irq_o), 0);
        // R5: ack rearms, backlog 2 -> 1
        step(0, 1, 0, 0);
        check(pend_work_o === 1'b1, "R5 ack rearms", int'(pend_work_o), 1);
        drain_count(n);
        check(n == 1, "R5 one tick left", n, 1);
        // R5 floor: ack at zero, then one expiry needs exactly one ack
        step(0, 1, 0, 0);
        step(1, 0, 0, 0);
        drain_count(n);
        check(n == 1, "R5 no underflow", n, 1);

        // R9: saturation
        step(0, 0, 1, 0);
        for (int i = 0; i < CNT_MAX + 40; i++) step(1, 0, 0, 0);
        drain_count(n);
        check(n == CNT_MAX, "R9 saturates", n, CNT_MAX);

        // R10: ack with expiry keeps backlog
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        step(1, 1, 0, 0);
        drain_count(n);
        check(n == 2, "R10 simultaneous ack and expiry", n, 2);

        // R7: reprog overrides expiry and slot
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        step(1, 1, 1, 1);
        check(pend_work_o === 1'b0 && irq_o === 1'b0, "R7 reprog clears",
              int'({pend_work_o, irq_o}), 0);
        step(1, 0, 0, 0);
        drain_count(n);
        check(n == 1, "R7 backlog restarted", n, 1);

        // R11: launch and ack together leave flag cleared
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        step(0, 1, 0, 1);
        check(irq_o === 1'b1, "R11 launch happens", int'(irq_o), 1);
        check(pend_work_o === 1'b0, "R11 ready stays cleared", int'(pend_work_o), 0);
        step(0, 0, 0, 1);
        check(irq_o === 1'b0, "R11 no second launch", int'(irq_o), 0);

        // random mix, fixed seed
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom;
            step(r[2:0] < 3, r[5:3] < 2, r[11:6] == 0, r[14:12] < 4);
        end
        finish_run();
    end

endmodule